// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational integer arithmetic logic unit for two's complement operands. It is built as a row of identical one-bit cells that share a ripple carry chain. Each cell can invert either of its operand bits and holds a full adder and a four-way output selector. The most significant cell also judges signed overflow and supplies the sign of the difference that the compare operation needs.

A 4-bit control code picks the operation. Bit 3 inverts operand `a`. Bit 2 inverts operand `b` and also supplies the carry into bit 0. Bits 1:0 pick the output of every cell. With this one code the unit performs AND, OR, NOR, addition, subtraction and a signed less-than compare. The block also reports three flags: an all-zero result, signed overflow, and the carry out of the top cell. A datapath uses it for address and data arithmetic. It can test two values for equality by subtracting them and reading the zero flag.

Top module: `sliced_alu`

## Requirements
- R1: Code 4'b0000 gives `result = a & b`.
- R2: Code 4'b0001 gives `result = a | b`.
- R3: Code 4'b0010 gives `result = (a + b) mod 2^WIDTH`.
- R4: Code 4'b0110 gives `result = (a - b) mod 2^WIDTH`.
- R5: Code 4'b1100 gives `result = ~(a | b)`.
- R6: Code 4'b0111 sets result bit 0 to the top bit of `(a - b) mod 2^WIDTH`. All other result bits are 0.
- R7: For code 4'b0010, `overflow` is 1 exactly when `a` and `b` have the same top bit and the result's top bit differs from it.
- R8: For code 4'b0110, `overflow` is 1 exactly when `a` and `b` have different top bits and the result's top bit differs from that of `a`. For every other code, `overflow` is 0.
- R9: `zero` is 1 exactly when every bit of `result` is 0.
- R10: For each of the six legal codes, `carry_out` is bit WIDTH of `a' + b' + code[2]`. Here `a'` is `a` inverted when code[3] is 1, and `b'` is `b` inverted when code[2] is 1.
- R11: Any code other than the six legal ones gives `result` 0, `overflow` 0 and `carry_out` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| alu_code | input | 4 | Bit 3 inverts a, bit 2 negates b, bits 1:0 select the cell output |
| result | output | WIDTH | Operation result |
| zero | output | 1 | Result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |
| carry_out | output | 1 | Carry out of the top cell |

## Verification
Several outputs are settled by the same carry chain in the same evaluation. This matters most when a subtract of equal operands must raise `zero` and `carry_out` together. It also matters in a compare whose difference overflows: the top cell's sign is fed back to bit 0 while `overflow` must stay low. The bench provokes these cases with directed operands: equal values, 0x80000000 against 0 in both orders, and 0x7FFFFFFF against 0x80000000. It also runs random operands for every code. Each cycle a behavioural model in the bench works out all four outputs from integer arithmetic, and the bench compares them together.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

   // per-cell output selection, carried in alu_code[1:0]
   typedef enum logic [1:0] {
      SEL_AND  = 2'b00,
      SEL_OR   = 2'b01,
      SEL_SUM  = 2'b10,
      SEL_LESS = 2'b11
   } cell_sel_e;

   // legal operation codes: {invert a, negate b, select}
   localparam logic [3:0] CODE_AND = 4'b0000;
   localparam logic [3:0] CODE_OR  = 4'b0001;
   localparam logic [3:0] CODE_ADD = 4'b0010;
   localparam logic [3:0] CODE_SUB = 4'b0110;
   localparam logic [3:0] CODE_SLT = 4'b0111;
   localparam logic [3:0] CODE_NOR = 4'b1100;

   typedef struct packed {
      logic      inv_a;
      logic      neg_b;
      cell_sel_e sel;
      logic      legal;
      logic      arith;
   } alu_ctl_t;

endpackage

// File: rtl/bsalu_decode.sv
module bsalu_decode
   import bsalu_pkg::*;
(
   input  logic [3:0] code_i,
   output alu_ctl_t   ctl_o
);

   always_comb begin
      ctl_o.inv_a = code_i[3];
      ctl_o.neg_b = code_i[2];
      ctl_o.sel   = cell_sel_e'(code_i[1:0]);
      unique case (code_i)
         CODE_AND, CODE_OR, CODE_SLT, CODE_NOR: begin
            ctl_o.legal = 1'b1;
            ctl_o.arith = 1'b0;
         end
         CODE_ADD, CODE_SUB: begin
            ctl_o.legal = 1'b1;
            ctl_o.arith = 1'b1;
         end
         default: begin
            ctl_o.legal = 1'b0;
            ctl_o.arith = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/bsalu_cell.sv
module bsalu_cell
   import bsalu_pkg::*;
#(
   parameter bit IS_TOP = 1'b0
)(
   input  logic      a_i,
   input  logic      b_i,
   input  logic      inv_a_i,
   input  logic      inv_b_i,
   input  logic      carry_i,
   input  logic      less_i,
   input  cell_sel_e sel_i,
   output logic      res_o,
   output logic      carry_o,
   output logic      sum_o,
   output logic      ovf_o
);

   logic ax;
   logic bx;
   logic sum;

   assign ax      = a_i ^ inv_a_i;
   assign bx      = b_i ^ inv_b_i;
   assign sum     = ax ^ bx ^ carry_i;
   assign carry_o = (ax & bx) | (ax & carry_i) | (bx & carry_i);
   assign sum_o   = sum;

   always_comb begin
      unique case (sel_i)
         SEL_AND:  res_o = ax & bx;
         SEL_OR:   res_o = ax | bx;
         SEL_SUM:  res_o = sum;
         SEL_LESS: res_o = less_i;
         default:  res_o = 1'b0;
      endcase
   end

   generate
      if (IS_TOP) begin : g_ovf
         // same-sign addends whose sum changes sign
         assign ovf_o = ~(ax ^ bx) & (sum ^ ax);
      end else begin : g_no_ovf
         assign ovf_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/bsalu_zero.sv
module bsalu_zero #(
   parameter int WIDTH = 32,
   parameter int GROUP = 8
)(
   input  logic [WIDTH-1:0] vec_i,
   output logic             zero_o
);

   localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;

   logic [NGRP-1:0] grp_any;

   generate
      if (GROUP < 1) begin : g_bad_group
         $error("bsalu_zero: GROUP must be at least 1");
      end
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         localparam int LO = g * GROUP;
         localparam int HI = ((LO + GROUP) < WIDTH) ? (LO + GROUP - 1) : (WIDTH - 1);
         assign grp_any[g] = |vec_i[HI:LO];
      end
   endgenerate

   assign zero_o = ~|grp_any;

endmodule

// File: rtl/sliced_alu.sv
module sliced_alu
   import bsalu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int ZERO_GROUP = 8
)(
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [3:0]       alu_code,
   output logic [WIDTH-1:0] result,
   output logic             zero,
   output logic             overflow,
   output logic             carry_out
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sliced_alu: WIDTH must be at least 2");
      end
   endgenerate

   alu_ctl_t         ctl;
   logic [WIDTH:0]   chain;
   logic [WIDTH-1:0] cell_res;
   logic             msb_sum;
   logic             msb_ovf;

   bsalu_decode u_dec (
      .code_i (alu_code),
      .ctl_o  (ctl)
   );

   assign chain[0] = ctl.neg_b;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_cell
         if (i == MSB) begin : g_top
            bsalu_cell #(.IS_TOP(1'b1)) u_cell (
               .a_i     (a[i]),
               .b_i     (b[i]),
               .inv_a_i (ctl.inv_a),
               .inv_b_i (ctl.neg_b),
               .carry_i (chain[i]),
               .less_i  (1'b0),
               .sel_i   (ctl.sel),
               .res_o   (cell_res[i]),
               .carry_o (chain[i+1]),
               .sum_o   (msb_sum),
               .ovf_o   (msb_ovf)
            );
         end else begin : g_low
            logic unused_sum;
            logic unused_ovf;
            logic less_in;
            if (i == 0) begin : g_fb
               assign less_in = msb_sum;
            end else begin : g_tie
               assign less_in = 1'b0;
            end
            bsalu_cell #(.IS_TOP(1'b0)) u_cell (
               .a_i     (a[i]),
               .b_i     (b[i]),
               .inv_a_i (ctl.inv_a),
               .inv_b_i (ctl.neg_b),
               .carry_i (chain[i]),
               .less_i  (less_in),
               .sel_i   (ctl.sel),
               .res_o   (cell_res[i]),
               .carry_o (chain[i+1]),
               .sum_o   (unused_sum),
               .ovf_o   (unused_ovf)
            );
         end
      end
   endgenerate

   assign result    = ctl.legal ? cell_res : '0;
   assign overflow  = ctl.arith & msb_ovf;
   assign carry_out = ctl.legal & chain[WIDTH];

   bsalu_zero #(.WIDTH(WIDTH), .GROUP(ZERO_GROUP)) u_zero (
      .vec_i  (result),
      .zero_o (zero)
   );

endmodule

// File: rtl/bsalu_checker.sv
module bsalu_checker
   import bsalu_pkg::*;
#(
   parameter int WIDTH = 32
)(
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic [3:0]       alu_code,
   input logic [WIDTH-1:0] result,
   input logic             zero,
   input logic             overflow,
   input logic             carry_out
);

   logic is_legal;
   assign is_legal = (alu_code == CODE_AND) || (alu_code == CODE_OR) ||
                     (alu_code == CODE_ADD) || (alu_code == CODE_SUB) ||
                     (alu_code == CODE_SLT) || (alu_code == CODE_NOR);

   always_comb begin
      // R9
      a_r9_zero_flag: assert (zero == (result == '0));
      // R6
      if (alu_code == CODE_SLT)
         a_r6_slt_upper_clear: assert (result[WIDTH-1:1] == '0);
      // R8
      if ((alu_code != CODE_ADD) && (alu_code != CODE_SUB))
         a_r8_no_overflow: assert (!overflow);
      // R7
      if ((alu_code == CODE_ADD) && (a[WIDTH-1] != b[WIDTH-1]))
         a_r7_mixed_sign_add: assert (!overflow);
      // R11
      if (!is_legal)
         a_r11_illegal_quiet: assert ((result == '0) && !carry_out);
      // R1
      if (alu_code == CODE_AND)
         a_r1_and_subset: assert ((result & ~a) == '0);
   end

endmodule

bind sliced_alu bsalu_checker #(.WIDTH(WIDTH)) u_chk (
   .a         (a),
   .b         (b),
   .alu_code  (alu_code),
   .result    (result),
   .zero      (zero),
   .overflow  (overflow),
   .carry_out (carry_out)
);

// File: tb/sliced_alu_tb_top.sv
module sliced_alu_tb_top;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic [3:0]   code = 4'b0000;
   logic [W-1:0] result;
   logic         zero;
   logic         overflow;
   logic         carry_out;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   sliced_alu #(.WIDTH(W)) dut_i (
      .a         (a),
      .b         (b),
      .alu_code  (code),
      .result    (result),
      .zero      (zero),
      .overflow  (overflow),
      .carry_out (carry_out)
   );

   function automatic string tag_of(input logic [3:0] c);
      case (c)
         4'b0000: return "R1";
         4'b0001: return "R2";
         4'b0010: return "R3";
         4'b0110: return "R4";
         4'b1100: return "R5";
         4'b0111: return "R6";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // behavioural reference built from the requirement text
   task automatic apply(input logic [W-1:0] xa, input logic [W-1:0] xb,
                        input logic [3:0] c);
      logic [W-1:0] er;
      logic         eo;
      logic         ec;
      logic [W-1:0] diff;
      logic [W:0]   wide;
      logic [W-1:0] ap;
      logic [W-1:0] bp;
      bit           legal;
      @(negedge clk);
      a = xa; b = xb; code = c;
      diff  = xa - xb;
      legal = 1'b1;
      eo    = 1'b0;
      case (c)
         4'b0000: er = xa & xb;
         4'b0001: er = xa | xb;
         4'b0010: begin
            er = xa + xb;
            eo = (xa[W-1] == xb[W-1]) && (er[W-1] != xa[W-1]);
         end
         4'b0110: begin
            er = diff;
            eo = (xa[W-1] != xb[W-1]) && (er[W-1] != xa[W-1]);
         end
         4'b0111: er = {{(W-1){1'b0}}, diff[W-1]};
         4'b1100: er = ~(xa | xb);
         default: begin er = '0; legal = 1'b0; end
      endcase
      ap   = c[3] ? ~xa : xa;
      bp   = c[2] ? ~xb : xb;
      wide = {1'b0, ap} + {1'b0, bp} + {{W{1'b0}}, c[2]};
      ec   = legal ? wide[W] : 1'b0;
      @(posedge clk);
      #1;
      check(tag_of(c), "result", result, er);
      check((c == 4'b0010) ? "R7" : "R8", "overflow", {{(W-1){1'b0}}, overflow},
            {{(W-1){1'b0}}, eo});
      check("R9", "zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, (er == '0)});
      check(legal ? "R10" : "R11", "carry_out", {{(W-1){1'b0}}, carry_out},
            {{(W-1){1'b0}}, ec});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // reset state: zero operands, AND code
      check("R1", "reset result", result, '0);
      check("R9", "reset zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});
      rst = 1'b0;

      // corner cases
      apply(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010); // R7 positive overflow
      apply(32'h8000_0000, 32'hFFFF_FFFF, 4'b0010); // R7 negative overflow
      apply(32'h8000_0000, 32'h0000_0001, 4'b0110); // R8 overflow on subtract
      apply(32'h1234_5678, 32'h1234_5678, 4'b0110); // R9 equal operands, R10 carry
      apply(32'h8000_0000, 32'h0000_0000, 4'b0111); // R6 most negative below zero
      apply(32'h0000_0000, 32'h8000_0000, 4'b0111); // R6 wrapped difference
      apply(32'h7FFF_FFFF, 32'h8000_0000, 4'b0111); // R6 with hidden overflow
      apply(32'h0000_0005, 32'h0000_0005, 4'b0111); // R6 equal gives 0
      apply(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010); // R3 wrap, R10 carry
      apply(32'h0000_0000, 32'h0000_0000, 4'b1100); // R5 all ones
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0110); // R8 no overflow, zero

      // every code, including unassigned ones (R11)
      for (int c = 0; c < 16; c++) begin
         apply(32'hDEAD_BEEF, 32'h0F0F_1234, c[3:0]);
         apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, c[3:0]);
      end

      // random operands for every legal code
      for (int k = 0; k < 60; k++) begin
         logic [W-1:0] ra;
         logic [W-1:0] rb;
         ra = $urandom();
         rb = $urandom();
         if (k % 10 == 0) rb = ra;
         apply(ra, rb, 4'b0000);
         apply(ra, rb, 4'b0001);
         apply(ra, rb, 4'b0010);
         apply(ra, rb, 4'b0110);
         apply(ra, rb, 4'b0111);
         apply(ra, rb, 4'b1100);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule